// File: doc/BRIEF.md
# Main Instruction Control Decoder

This block turns the 6-bit opcode field of the instruction being executed into the full set of datapath control lines for a single-cycle 32-bit load/store processor. It recognises five instruction classes: register-to-register operations, word load, word store, branch-if-equal and unconditional jump. From the opcode alone it chooses the destination register field and the second ALU operand. It also decides the write-back source, enables the register-file write and the data-memory read or write, flags branch and jump, and passes a 2-bit class code to the ALU control stage.

The decoder is purely combinational and holds no state. Its outputs follow the opcode within the same cycle and do not depend on earlier instructions. Every line that a given class does not care about is driven to 0, so each output has a single defined value for every opcode. Any opcode outside the five supported ones leaves every output low. Such an instruction then writes no register and no memory location and does not redirect the program counter.

Top module: `main_ctl_decoder`

## Requirements
- R1: Opcode 6'b000000 (register type) drives reg_dst=1, reg_write=1 and alu_op=2'b10, with alu_src, mem_to_reg, mem_read, mem_write, branch and jump all 0.
- R2: Opcode 6'b100011 (load word) drives alu_src=1, mem_to_reg=1, reg_write=1, mem_read=1 and alu_op=2'b00, with reg_dst, mem_write, branch and jump all 0.
- R3: Opcode 6'b101011 (store word) drives alu_src=1, mem_write=1 and alu_op=2'b00, with reg_dst, mem_to_reg, reg_write, mem_read, branch and jump all 0.
- R4: Opcode 6'b000100 (branch-if-equal) drives branch=1 and alu_op=2'b01 (subtract), with every other output 0, including mem_to_reg.
- R5: Opcode 6'b000010 (jump) drives jump=1 and alu_op=2'b00, with every other output 0.
- R6: Every other opcode value drives all outputs to 0. In particular, reg_write, mem_write, mem_read, branch and jump are all 0.
- R7: The outputs depend only on the present opcode. The same opcode gives the same outputs whatever opcode came before it.
- R8: mem_read and mem_write are never both 1, and branch and jump are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Opcode field of the current instruction |
| reg_dst | output | 1 | 1 selects the rd field as write register, 0 selects rt |
| alu_src | output | 1 | 1 selects the sign-extended immediate as the second ALU operand |
| mem_to_reg | output | 1 | 1 writes back data-memory output, 0 writes back the ALU result |
| reg_write | output | 1 | Register-file write enable |
| mem_read | output | 1 | Data-memory read enable |
| mem_write | output | 1 | Data-memory write enable |
| branch | output | 1 | Conditional branch instruction |
| jump | output | 1 | Unconditional jump instruction |
| alu_op | output | 2 | 00 add, 01 subtract, 10 use the function field |

## Verification
The cases that are hardest to reach are the 59 opcodes the decoder must reject. Several of them differ from a supported opcode in only one bit, such as 6'b100111 next to the load or 6'b000110 next to the branch. A single wrong don't-care term in the decode would let one of these through. The stimulus therefore walks all 64 opcode values, once upward and once downward. Each value is then reached from two different predecessors, which also tests the claim that the decoder keeps no history.

// File: rtl/main_ctl_decoder.sv
module main_ctl_decoder #(
  parameter logic [5:0] OP_RTYPE = 6'b000000,
  parameter logic [5:0] OP_LOAD  = 6'b100011,
  parameter logic [5:0] OP_STORE = 6'b101011,
  parameter logic [5:0] OP_BEQ   = 6'b000100,
  parameter logic [5:0] OP_JUMP  = 6'b000010
) (
  input  logic [5:0] opcode,
  output logic       reg_dst,
  output logic       alu_src,
  output logic       mem_to_reg,
  output logic       reg_write,
  output logic       mem_read,
  output logic       mem_write,
  output logic       branch,
  output logic       jump,
  output logic [1:0] alu_op
);

  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNCT = 2'b10;

  typedef struct packed {
    logic       dst;
    logic       src;
    logic       m2r;
    logic       rwr;
    logic       mrd;
    logic       mwr;
    logic       br;
    logic       jmp;
    logic [1:0] aop;
  } ctl_t;

  ctl_t ctl;

  always_comb begin
    ctl = '0;
    unique case (opcode)
      OP_RTYPE: begin
        ctl.dst = 1'b1;
        ctl.rwr = 1'b1;
        ctl.aop = ALU_FUNCT;
      end
      OP_LOAD: begin
        ctl.src = 1'b1;
        ctl.m2r = 1'b1;
        ctl.rwr = 1'b1;
        ctl.mrd = 1'b1;
        ctl.aop = ALU_ADD;
      end
      OP_STORE: begin
        ctl.src = 1'b1;
        ctl.mwr = 1'b1;
        ctl.aop = ALU_ADD;
      end
      OP_BEQ: begin
        ctl.br  = 1'b1;
        ctl.aop = ALU_SUB;
      end
      OP_JUMP: begin
        ctl.jmp = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  assign reg_dst    = ctl.dst;
  assign alu_src    = ctl.src;
  assign mem_to_reg = ctl.m2r;
  assign reg_write  = ctl.rwr;
  assign mem_read   = ctl.mrd;
  assign mem_write  = ctl.mwr;
  assign branch     = ctl.br;
  assign jump       = ctl.jmp;
  assign alu_op     = ctl.aop;

  always_comb begin
    // R8
    mem_excl_chk: assert (!(ctl.mrd && ctl.mwr));
    // R8
    flow_excl_chk: assert (!(ctl.br && ctl.jmp));
    // R1
    rtype_wr_chk: assert (!ctl.dst || (ctl.rwr && ctl.aop == ALU_FUNCT));
    // R2
    load_wb_chk: assert (!ctl.mrd || (ctl.m2r && ctl.rwr && ctl.src));
    // R3
    store_nowr_chk: assert (!ctl.mwr || (!ctl.rwr && ctl.src));
    // R4
    beq_sub_chk: assert (!ctl.br || (ctl.aop == ALU_SUB && !ctl.rwr));
    // R5
    jump_inert_chk: assert (!ctl.jmp || (!ctl.rwr && !ctl.mwr && !ctl.mrd));
    // R6
    bad_op_chk: assert (opcode == OP_RTYPE || opcode == OP_LOAD || opcode == OP_STORE ||
                        opcode == OP_BEQ || opcode == OP_JUMP || ctl == '0);
  end

endmodule

// File: tb/tb_main_ctl_decoder.sv
module tb_main_ctl_decoder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump;
  logic [1:0] alu_op;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  main_ctl_decoder dut (
    .opcode(opcode), .reg_dst(reg_dst), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
    .reg_write(reg_write), .mem_read(mem_read), .mem_write(mem_write),
    .branch(branch), .jump(jump), .alu_op(alu_op)
  );

  // expected word: {dst,src,m2r,rwr,mrd,mwr,br,jmp,aop[1:0]}
  function automatic logic [9:0] model(input int op);
    if (op == 0)       return 10'b1001_0000_10;
    else if (op == 35) return 10'b0111_1000_00;
    else if (op == 43) return 10'b0100_0100_00;
    else if (op == 4)  return 10'b0000_0010_01;
    else if (op == 2)  return 10'b0000_0001_00;
    else               return 10'b0;
  endfunction

  function automatic string tag(input int op);
    if (op == 0)       return "R1";
    else if (op == 35) return "R2";
    else if (op == 43) return "R3";
    else if (op == 4)  return "R4";
    else if (op == 2)  return "R5";
    else               return "R6";
  endfunction

  task automatic check(input string req);
    logic [9:0] got, exp;
    got = {reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump, alu_op};
    exp = model(int'(opcode));
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b actual=%b expected=%b", req, opcode, got, exp);
    end
    n_cmp++;
    if ((mem_read && mem_write) || (branch && jump)) begin
      n_bad++;
      $display("FAIL R8 op=%b actual=%b expected=no overlap", opcode, got);
    end
  endtask

  task automatic apply(input int op, input string req);
    @(posedge clk);
    #1 opcode = 6'(op);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset");
    for (int op = 0; op < 64; op++) apply(op, tag(op));
    // R7: descending walk reaches each opcode from a different predecessor
    for (int op = 63; op >= 0; op--) apply(op, "R7");
    apply(43, "R3");
    apply(35, "R2");
    apply(4, "R4");
    apply(2, "R5");
    apply(0, "R1");
    apply(39, "R6");
    apply(6, "R6");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule